// File: doc/BRIEF.md
# Zero-Sequence Differential Trip Gate

This block converts the pickup of a zero-sequence current differential element into a circuit-breaker trip command. The pickup is qualified by several conditions. The function must be enabled. Neither block command may be active. The communication link to the remote terminal must be healthy. The GPS/backup mode inhibit must be clear. The zero-sequence current magnitude at each terminal must stay below 2 per unit. The zero-sequence fail-safe permit must be present.

A qualified pickup must persist for a settable number of millisecond ticks before the trip is issued. An instant-trip command skips that wait. The trip can start autoreclose when the autoreclose-start switch is on.

The block also forms the phase fail-safe permit. A two-bit setting selects the overcurrent flag, the current-change flag, or their OR. When the setting is off, the permit is held high.

Top module: `zsd_trip_gate`

## Requirements
- R1: With the gated condition true and `inst_trip_i` low, `trip_o` rises only after `delay_ms_i` cycles with `ms_tick_i` high have been seen while the condition held. A delay of 0 trips at once. The valid range is 0 to 10000.
- R2: When the gated condition drops, `trip_o` falls in the same cycle. The tick count restarts from zero, so an interrupted wait does not accumulate.
- R3: `inst_trip_i` high makes a gated condition trip immediately, whatever the delay setting.
- R4: Either `block_a_i` or `block_b_i` high forces `trip_o` low, including during instant trip.
- R5: Any bit of `comm_fault_i` high forces `trip_o` low. Bit 0 is a data error, bit 1 is a sampling-synchronism fault and bit 2 is loss of received data.
- R6: `trip_o` is low while `i0_local_i` or `i0_remote_i` is at least 0x0200 (2 pu, with 1 pu = 0x0100). A value of 0x01FF does not inhibit.
- R7: `mode_block_i` high (GPS-mode setting or backup mode) forces `trip_o` low.
- R8: `en_i` low or `diff_pickup_i` low gives `trip_o` low.
- R9: With `fs_zs_en_i` high, a trip requires `zs_chg_i` high. With `fs_zs_en_i` low, the permit is held at 1.
- R10: `ph_permit_o` follows `fs_ph_sel_i`. 00 gives 1, 01 gives `ph_oc_i`, 10 gives `ph_chg_i`, and 11 gives `ph_oc_i | ph_chg_i`.
- R11: `ar_start_o` equals `trip_o & ar_en_i`.
- R12: While `rst_ni` is low, the tick count is zero and `trip_o` is low for any nonzero delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low async reset |
| ms_tick_i | input | 1 | one-cycle millisecond strobe |
| en_i | input | 1 | function enable switch |
| ar_en_i | input | 1 | autoreclose-start switch |
| delay_ms_i | input | 14 | trip delay in ms |
| fs_ph_sel_i | input | 2 | phase fail-safe source select |
| fs_zs_en_i | input | 1 | zero-sequence fail-safe switch |
| ph_oc_i | input | 1 | phase overcurrent flag |
| ph_chg_i | input | 1 | phase current-change flag |
| zs_chg_i | input | 1 | zero-sequence current-change flag |
| diff_pickup_i | input | 1 | differential element output |
| inst_trip_i | input | 1 | instant-trip command |
| block_a_i | input | 1 | block command A |
| block_b_i | input | 1 | block command B |
| comm_fault_i | input | 3 | link fault flags |
| mode_block_i | input | 1 | GPS/backup mode inhibit |
| i0_local_i | input | 16 | local zero-sequence current sum |
| i0_remote_i | input | 16 | remote zero-sequence current sum |
| trip_o | output | 1 | breaker trip |
| ar_start_o | output | 1 | autoreclose start |
| ph_permit_o | output | 1 | phase fail-safe permit |

## Verification
The assertions take `ms_tick_i` to be a single-cycle strobe. They take `delay_ms_i` to be held steady while a wait runs, and the delay-related property is disabled in any cycle where the setting changes. The stimulus changes the delay only while the gated condition is low. It pulses the tick for exactly one clock edge, and it drives all inputs at the falling edge, so every setting is stable across each rising edge.

// File: rtl/zsd_pkg.sv
package zsd_pkg;
  typedef enum logic [1:0] {
    FS_OFF  = 2'b00,
    FS_OC   = 2'b01,
    FS_CHG  = 2'b10,
    FS_BOTH = 2'b11
  } fs_sel_e;

  localparam int unsigned N_TERM = 2;
  localparam int unsigned N_BLK  = 2;
  localparam int unsigned N_COMM = 3;
endpackage

// File: rtl/zsd_failsafe_sel.sv
module zsd_failsafe_sel
  import zsd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] ph_sel_i,
  input  logic       ph_oc_i,
  input  logic       ph_chg_i,
  input  logic       zs_en_i,
  input  logic       zs_chg_i,
  output logic       ph_permit_o,
  output logic       zs_permit_o
);
  always_comb begin
    unique case (fs_sel_e'(ph_sel_i))
      FS_OC:   ph_permit_o = ph_oc_i;
      FS_CHG:  ph_permit_o = ph_chg_i;
      FS_BOTH: ph_permit_o = ph_oc_i | ph_chg_i;
      default: ph_permit_o = 1'b1;
    endcase
  end

  assign zs_permit_o = zs_en_i ? zs_chg_i : 1'b1;

  // R10
  ph_off_permit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_sel_i == 2'b00) |-> ph_permit_o);
  // R10
  ph_none_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_sel_i != 2'b00 && !ph_oc_i && !ph_chg_i) |-> !ph_permit_o);
  // R9
  zs_off_permit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !zs_en_i |-> zs_permit_o);
endmodule

// File: rtl/zsd_inhibit.sv
module zsd_inhibit
  import zsd_pkg::*;
#(
  parameter int unsigned      CUR_W = 16,
  parameter logic [CUR_W-1:0] LIMIT = 16'h0200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              pick_i,
  input  logic              permit_i,
  input  logic [N_BLK-1:0]  block_i,
  input  logic [N_COMM-1:0] comm_i,
  input  logic              mode_i,
  input  logic [CUR_W-1:0]  cur_i [N_TERM],
  output logic              qual_o
);
  logic [N_TERM-1:0] big;

  for (genvar g = 0; g < N_TERM; g++) begin : g_term
    assign big[g] = (cur_i[g] >= LIMIT);
  end

  logic inhibit;
  assign inhibit = (|block_i) | (|comm_i) | mode_i | (|big);
  assign qual_o  = en_i & pick_i & permit_i & ~inhibit;

  // R4
  blk_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|block_i) |-> !qual_o);
  // R5
  comm_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|comm_i) |-> !qual_o);
  // R7
  mode_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i |-> !qual_o);
endmodule

// File: rtl/zsd_delay_timer.sv
module zsd_delay_timer #(
  parameter int unsigned MAX_MS = 10000,
  localparam int unsigned CW    = $clog2(MAX_MS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          run_i,
  input  logic [CW-1:0] delay_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (!run_i)                  cnt_q <= '0;
    else if (tick_i && cnt_q < delay_i) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q >= delay_i);

  // R1: count moves up only on a tick
  cnt_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0 && cnt_q != $past(cnt_q)) |-> $past(tick_i));
  // R2
  cnt_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && $stable(delay_i) && delay_i != '0) |=> !done_o);
endmodule

// File: rtl/zsd_trip_gate.sv
module zsd_trip_gate
  import zsd_pkg::*;
#(
  parameter int unsigned MAX_DELAY_MS = 10000,
  parameter int unsigned CUR_W        = 16,
  parameter int unsigned PU_ONE       = 256,
  parameter int unsigned INHIBIT_PU   = 2,
  localparam int unsigned DLY_W       = $clog2(MAX_DELAY_MS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ms_tick_i,
  input  logic             en_i,
  input  logic             ar_en_i,
  input  logic [DLY_W-1:0] delay_ms_i,
  input  logic [1:0]       fs_ph_sel_i,
  input  logic             fs_zs_en_i,
  input  logic             ph_oc_i,
  input  logic             ph_chg_i,
  input  logic             zs_chg_i,
  input  logic             diff_pickup_i,
  input  logic             inst_trip_i,
  input  logic             block_a_i,
  input  logic             block_b_i,
  input  logic [2:0]       comm_fault_i,
  input  logic             mode_block_i,
  input  logic [CUR_W-1:0] i0_local_i,
  input  logic [CUR_W-1:0] i0_remote_i,
  output logic             trip_o,
  output logic             ar_start_o,
  output logic             ph_permit_o
);
  localparam logic [CUR_W-1:0] LIMIT = CUR_W'(PU_ONE * INHIBIT_PU);

  logic             zs_permit, qual, done;
  logic [CUR_W-1:0] cur [N_TERM];

  assign cur[0] = i0_local_i;
  assign cur[1] = i0_remote_i;

  zsd_failsafe_sel i_fs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ph_sel_i    (fs_ph_sel_i),
    .ph_oc_i     (ph_oc_i),
    .ph_chg_i    (ph_chg_i),
    .zs_en_i     (fs_zs_en_i),
    .zs_chg_i    (zs_chg_i),
    .ph_permit_o (ph_permit_o),
    .zs_permit_o (zs_permit)
  );

  zsd_inhibit #(.CUR_W(CUR_W), .LIMIT(LIMIT)) i_inh (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .pick_i   (diff_pickup_i),
    .permit_i (zs_permit),
    .block_i  ({block_b_i, block_a_i}),
    .comm_i   (comm_fault_i),
    .mode_i   (mode_block_i),
    .cur_i    (cur),
    .qual_o   (qual)
  );

  zsd_delay_timer #(.MAX_MS(MAX_DELAY_MS)) i_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (ms_tick_i),
    .run_i   (qual),
    .delay_i (delay_ms_i),
    .done_o  (done)
  );

  assign trip_o     = qual & (inst_trip_i | done);
  assign ar_start_o = trip_o & ar_en_i;

  // R4
  trip_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (block_a_i | block_b_i) |-> !trip_o);
  // R6
  big_cur_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (i0_local_i >= LIMIT || i0_remote_i >= LIMIT) |-> !trip_o);
  // R11
  ar_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ar_start_o |-> (trip_o && ar_en_i));
  // R1
  delayed_trip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trip_o && !inst_trip_i && delay_ms_i != '0 && $stable(delay_ms_i)) |-> $past(qual));
  // R9
  zs_permit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fs_zs_en_i && !zs_chg_i) |-> !trip_o);
endmodule

// File: tb/test_zsd_trip_gate.sv
module test_zsd_trip_gate;
  logic        clk = 1'b0, rst_ni = 1'b0, tick = 1'b0;
  logic        en = 0, ar_en = 0, fs_zs_en = 0, ph_oc = 0, ph_chg = 0, zs_chg = 0;
  logic        pick = 0, inst = 0, blk_a = 0, blk_b = 0, mode = 0;
  logic [1:0]  ph_sel = 2'b00;
  logic [2:0]  comm = 3'b000;
  logic [13:0] dly = '0;
  logic [15:0] loc = '0, rem = '0;
  logic        trip, ar_start, ph_permit;
  int          n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  zsd_trip_gate i_zsd_trip_gate (
    .clk_i(clk), .rst_ni(rst_ni), .ms_tick_i(tick), .en_i(en), .ar_en_i(ar_en),
    .delay_ms_i(dly), .fs_ph_sel_i(ph_sel), .fs_zs_en_i(fs_zs_en), .ph_oc_i(ph_oc),
    .ph_chg_i(ph_chg), .zs_chg_i(zs_chg), .diff_pickup_i(pick), .inst_trip_i(inst),
    .block_a_i(blk_a), .block_b_i(blk_b), .comm_fault_i(comm), .mode_block_i(mode),
    .i0_local_i(loc), .i0_remote_i(rem), .trip_o(trip), .ar_start_o(ar_start),
    .ph_permit_o(ph_permit)
  );

  // {en,pick,inst,blk_a,blk_b,comm[2:0],mode,fs_zs_en,zs_chg,ar_en,loc,rem,exp_trip,exp_ar}
  localparam int NV = 16;
  localparam logic [45:0] VEC [NV] = '{
    {1'b1,1'b1,1'b0,1'b0,1'b0,3'b000,1'b0,1'b0,1'b0,1'b1,16'h0080,16'h0080,1'b1,1'b1}, // R1 R11
    {1'b1,1'b1,1'b0,1'b0,1'b0,3'b000,1'b0,1'b0,1'b0,1'b0,16'h0080,16'h0080,1'b1,1'b0}, // R11
    {1'b1,1'b0,1'b0,1'b0,1'b0,3'b000,1'b0,1'b0,1'b0,1'b1,16'h0080,16'h0080,1'b0,1'b0}, // R8
    {1'b0,1'b1,1'b0,1'b0,1'b0,3'b000,1'b0,1'b0,1'b0,1'b1,16'h0080,16'h0080,1'b0,1'b0}, // R8
    {1'b1,1'b1,1'b0,1'b1,1'b0,3'b000,1'b0,1'b0,1'b0,1'b1,16'h0080,16'h0080,1'b0,1'b0}, // R4
    {1'b1,1'b1,1'b0,1'b0,1'b1,3'b000,1'b0,1'b0,1'b0,1'b1,16'h0080,16'h0080,1'b0,1'b0}, // R4
    {1'b1,1'b1,1'b0,1'b0,1'b0,3'b001,1'b0,1'b0,1'b0,1'b1,16'h0080,16'h0080,1'b0,1'b0}, // R5
    {1'b1,1'b1,1'b0,1'b0,1'b0,3'b100,1'b0,1'b0,1'b0,1'b1,16'h0080,16'h0080,1'b0,1'b0}, // R5
    {1'b1,1'b1,1'b0,1'b0,1'b0,3'b000,1'b1,1'b0,1'b0,1'b1,16'h0080,16'h0080,1'b0,1'b0}, // R7
    {1'b1,1'b1,1'b0,1'b0,1'b0,3'b000,1'b0,1'b0,1'b0,1'b1,16'h0200,16'h0080,1'b0,1'b0}, // R6
    {1'b1,1'b1,1'b0,1'b0,1'b0,3'b000,1'b0,1'b0,1'b0,1'b1,16'h01FF,16'h01FF,1'b1,1'b1}, // R6
    {1'b1,1'b1,1'b0,1'b0,1'b0,3'b000,1'b0,1'b0,1'b0,1'b1,16'h0080,16'h0200,1'b0,1'b0}, // R6
    {1'b1,1'b1,1'b0,1'b0,1'b0,3'b000,1'b0,1'b1,1'b0,1'b1,16'h0080,16'h0080,1'b0,1'b0}, // R9
    {1'b1,1'b1,1'b0,1'b0,1'b0,3'b000,1'b0,1'b1,1'b1,1'b1,16'h0080,16'h0080,1'b1,1'b1}, // R9
    {1'b1,1'b1,1'b0,1'b0,1'b0,3'b000,1'b0,1'b0,1'b0,1'b1,16'h0000,16'hFFFF,1'b0,1'b0}, // R6
    {1'b1,1'b1,1'b0,1'b0,1'b0,3'b010,1'b0,1'b0,1'b0,1'b1,16'h0080,16'h0080,1'b0,1'b0}  // R5
  };

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    #1;
  endtask

  task automatic good_state();
    en = 1; pick = 1; inst = 0; blk_a = 0; blk_b = 0; comm = 0; mode = 0;
    fs_zs_en = 0; zs_chg = 0; ar_en = 1; loc = 16'h0080; rem = 16'h0080;
  endtask

  initial begin
    #1000000;
    n_chk++; n_err++;
    $display("FAIL watchdog: got hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    // R12 reset state
    repeat (3) @(negedge clk);
    #1;
    chk("R12 reset trip", trip, 1'b0);
    chk("R12 reset ar", ar_start, 1'b0);
    rst_ni = 1'b1;

    // table walk at zero delay
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {en, pick, inst, blk_a, blk_b, comm, mode, fs_zs_en, zs_chg, ar_en, loc, rem} = VEC[i][45:2];
      #1;
      chk("table trip", trip, VEC[i][1]);
      chk("table ar", ar_start, VEC[i][0]);
    end

    // R1 delay of three ticks
    @(negedge clk); good_state(); pick = 0; dly = 14'd3;
    @(negedge clk); pick = 1; #1;
    chk("R1 no tick yet", trip, 1'b0);
    pulse_tick(); pulse_tick();
    chk("R1 after 2 ticks", trip, 1'b0);
    pulse_tick();
    chk("R1 after 3 ticks", trip, 1'b1);
    chk("R11 ar with delayed trip", ar_start, 1'b1);

    // R2 drop and restart
    @(negedge clk); pick = 0; #1;
    chk("R2 same-cycle drop", trip, 1'b0);
    @(negedge clk); pick = 1; #1;
    chk("R2 count restarted", trip, 1'b0);
    pulse_tick(); pulse_tick();
    @(negedge clk); pick = 0;
    @(negedge clk); pick = 1;
    pulse_tick(); pulse_tick();
    chk("R2 interrupted wait", trip, 1'b0);
    pulse_tick();
    chk("R2 full wait after restart", trip, 1'b1);

    // R3 instant trip
    @(negedge clk); pick = 0;
    @(negedge clk); dly = 14'd10000;
    @(negedge clk); pick = 1; #1;
    chk("R3 long delay no inst", trip, 1'b0);
    inst = 1; #1;
    chk("R3 instant", trip, 1'b1);
    blk_a = 1; #1;
    chk("R4 block over instant", trip, 1'b0);
    blk_a = 0; pick = 0; #1;
    chk("R8 no pickup instant", trip, 1'b0);
    inst = 0;

    // R12 reset clears an elapsed count
    @(negedge clk); dly = 14'd2;
    @(negedge clk); pick = 1;
    pulse_tick(); pulse_tick();
    chk("R1 two-tick trip", trip, 1'b1);
    @(negedge clk); rst_ni = 0; #1;
    chk("R12 reset clears", trip, 1'b0);
    @(negedge clk); rst_ni = 1; #1;
    chk("R12 after release", trip, 1'b0);

    // R10 phase permit select
    ph_sel = 2'b00; ph_oc = 0; ph_chg = 0; #1;
    chk("R10 off held", ph_permit, 1'b1);
    ph_sel = 2'b01; ph_oc = 1; #1;
    chk("R10 oc sel", ph_permit, 1'b1);
    ph_oc = 0; ph_chg = 1; #1;
    chk("R10 oc sel ignores chg", ph_permit, 1'b0);
    ph_sel = 2'b10; #1;
    chk("R10 chg sel", ph_permit, 1'b1);
    ph_chg = 0; ph_oc = 1; #1;
    chk("R10 chg sel ignores oc", ph_permit, 1'b0);
    ph_sel = 2'b11; ph_oc = 0; ph_chg = 1; #1;
    chk("R10 both or", ph_permit, 1'b1);
    ph_chg = 0; #1;
    chk("R10 both none", ph_permit, 1'b0);

    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule